// File: doc/BRIEF.md
# Byte-Addressed Pin Controller with Per-Pin Interrupt Sensing

This block is a memory-mapped general-purpose pin controller. Every pin has one byte in each of nine register arrays. These arrays cover direction, drive level, sampled level, interrupt enable, polarity, edge/level select, status clear, latched status and dual-edge select. Only bit 0 of each byte carries meaning. A simple byte-wide register port with separate read and write strobes reaches all arrays. Read data comes back one cycle after the read strobe.

Pin inputs pass through a two-flop synchroniser. The block then compares each synchronised value with its value one cycle earlier to find edges. Each pin latches a status bit when its configured event occurs: an active level, a single edge of chosen direction, or either edge. Software clears status by writing 1 to the pin's clear byte. A pin drives an interrupt line only while both its status and its enable are set. Pins are spread over seven registered interrupt lines, and pin p feeds line p mod 7.

Top module: `pinbyte_gpio_irq`

## Requirements
- R1: While reset is held and after it is released, every configuration bit is 0. Every pin is therefore an output (pin_oe = 1) driving 0, and every interrupt line is low.
- R2: The direction array sits at 0x800 + pin. When bit 0 of the pin's direction byte is 1, the pin is an input and pin_oe is 0. When bit 0 is 0, pin_oe is 1 and pin_out follows bit 0 of the output array at 0x900 + pin. Both arrays read back what was written.
- R3: A read of 0xA00 + pin returns in bit 0 the pin level after a two-flop synchroniser. bus_rdata is registered and holds the value selected at the clock edge where bus_rd is high.
- R4: Level mode applies when bit 0 of the edge array (0xD00 + pin) is 0. In this mode, polarity (0xC00 + pin) = 1 sets status while the synchronised input is 1, and polarity = 0 sets status while it is 0. The reset configuration is therefore active-low level mode.
- R5: Edge mode applies when edge = 1 and dual-edge (0xF80 + pin) = 0. Polarity = 1 sets status on a 0-to-1 change of the synchronised input, and polarity = 0 sets it on a 1-to-0 change.
- R6: With edge = 1 and dual = 1, both changes set status and polarity has no effect.
- R7: Writing a byte with bit 0 = 1 to 0xE00 + pin clears that pin's status, which reads at 0xF00 + pin. Writing bit 0 = 0 there has no effect. The clear array always reads 0.
- R8: Interrupt line g (0..6) is a registered OR of (status AND enable) over pins p with p mod 7 = g. The enable array sits at 0xB00 + pin. Status still latches while enable is 0, but a masked pin never raises a line.
- R9: If a pin's event and a clear write to that pin fall in the same cycle, the status stays set.
- R10: Only bit 0 of a written byte is stored, and read data bits 7:1 are always 0. Reads of addresses outside the nine arrays, or of pin indices at or above NUM_PINS, return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output level |
| irq_out | output | NUM_IRQ | Aggregated interrupt lines |

## Verification
An event latch and a software clear can land on the same pin in the same cycle. The bench provokes this by raising a pin configured for rising edges. It then issues the clear write so that the write's clock edge is the third edge after the pin change, the edge at which the synchronised rise is detected. The status byte read afterwards must still be 1. A separate clear with no event must bring it to 0.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  // Upper address nibble selects the array; the low byte carries the pin
  localparam logic [3:0] BANK_DIR  = 4'h8;
  localparam logic [3:0] BANK_OUT  = 4'h9;
  localparam logic [3:0] BANK_IN   = 4'hA;
  localparam logic [3:0] BANK_EN   = 4'hB;
  localparam logic [3:0] BANK_POL  = 4'hC;
  localparam logic [3:0] BANK_EDGE = 4'hD;
  localparam logic [3:0] BANK_CLR  = 4'hE;
  localparam logic [3:0] BANK_TOP  = 4'hF; // status low half, dual high half

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DIR, SEL_OUT, SEL_IN, SEL_EN,
    SEL_POL, SEL_EDGE, SEL_CLR, SEL_STAT, SEL_DUAL
  } arr_sel_e;
endpackage

// File: rtl/gpb_regfile.sv
module gpb_regfile
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [NUM_PINS-1:0] sync_lvl,
  input  logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] edge_q,
  output logic [NUM_PINS-1:0] dual_q,
  output logic [NUM_PINS-1:0] clr_pulse,
  output logic [7:0]          rdata
);
  localparam int PW = $clog2(NUM_PINS);

  logic [3:0]    bank;
  logic [7:0]    idx;
  arr_sel_e      sel;
  logic          hit;
  logic [PW-1:0] pidx;
  logic          rbit;

  assign bank = addr[ADDR_W-1 -: 4];

  always_comb begin
    sel = SEL_NONE;
    idx = addr[7:0];
    unique case (bank)
      BANK_DIR:  sel = SEL_DIR;
      BANK_OUT:  sel = SEL_OUT;
      BANK_IN:   sel = SEL_IN;
      BANK_EN:   sel = SEL_EN;
      BANK_POL:  sel = SEL_POL;
      BANK_EDGE: sel = SEL_EDGE;
      BANK_CLR:  sel = SEL_CLR;
      BANK_TOP: begin
        sel = addr[7] ? SEL_DUAL : SEL_STAT;
        idx = {1'b0, addr[6:0]};
      end
      default:   sel = SEL_NONE;
    endcase
  end

  assign hit  = (sel != SEL_NONE) && (idx < 8'(NUM_PINS));
  assign pidx = idx[PW-1:0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel_me;
    logic dir_r, out_r, en_r, pol_r, edge_r, dual_r;

    assign sel_me = wr && hit && (pidx == PW'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_r  <= 1'b0;
        out_r  <= 1'b0;
        en_r   <= 1'b0;
        pol_r  <= 1'b0;
        edge_r <= 1'b0;
        dual_r <= 1'b0;
      end else if (sel_me) begin
        case (sel)
          SEL_DIR:  dir_r  <= wdata[0];
          SEL_OUT:  out_r  <= wdata[0];
          SEL_EN:   en_r   <= wdata[0];
          SEL_POL:  pol_r  <= wdata[0];
          SEL_EDGE: edge_r <= wdata[0];
          SEL_DUAL: dual_r <= wdata[0];
          default:  ;
        endcase
      end
    end

    assign dir_q[p]     = dir_r;
    assign out_q[p]     = out_r;
    assign en_q[p]      = en_r;
    assign pol_q[p]     = pol_r;
    assign edge_q[p]    = edge_r;
    assign dual_q[p]    = dual_r;
    assign clr_pulse[p] = sel_me && (sel == SEL_CLR) && wdata[0];
  end

  always_comb begin
    rbit = 1'b0;
    if (hit) begin
      case (sel)
        SEL_DIR:  rbit = dir_q[pidx];
        SEL_OUT:  rbit = out_q[pidx];
        SEL_IN:   rbit = sync_lvl[pidx];
        SEL_EN:   rbit = en_q[pidx];
        SEL_POL:  rbit = pol_q[pidx];
        SEL_EDGE: rbit = edge_q[pidx];
        SEL_STAT: rbit = status[pidx];
        SEL_DUAL: rbit = dual_q[pidx];
        default:  rbit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= 8'h00;
    else if (rd) rdata <= {7'b0, rbit};
  end

  AST_MISS_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit) |=> ($stable(dir_q) && $stable(out_q) && $stable(en_q) &&
                      $stable(pol_q) && $stable(edge_q) && $stable(dual_q))); // R10
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CLR) |=> (rdata == 8'h00)); // R7
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] raw,
  output logic [NUM_PINS-1:0] lvl,
  output logic [NUM_PINS-1:0] lvl_d
);
  logic [NUM_PINS-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= '0;
      lvl   <= '0;
      lvl_d <= '0;
    end else begin
      meta  <= raw;
      lvl   <= meta;
      lvl_d <= lvl;
    end
  end

  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || (lvl == $past(meta))); // R3
endmodule

// File: rtl/gpb_event.sv
module gpb_event #(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] lvl_d,
  input  logic [NUM_PINS-1:0] edge_q,
  input  logic [NUM_PINS-1:0] dual_q,
  input  logic [NUM_PINS-1:0] pol_q,
  input  logic [NUM_PINS-1:0] clr_pulse,
  output logic [NUM_PINS-1:0] status
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall, evt, stat_r;

    assign rise = lvl[p] & ~lvl_d[p];
    assign fall = ~lvl[p] & lvl_d[p];

    always_comb begin
      if (!edge_q[p])     evt = pol_q[p] ? lvl[p] : ~lvl[p];
      else if (dual_q[p]) evt = rise | fall;
      else                evt = pol_q[p] ? rise : fall;
    end

    // event has priority over a same-cycle clear
    always_ff @(posedge clk) begin
      if (rst)               stat_r <= 1'b0;
      else if (evt)          stat_r <= 1'b1;
      else if (clr_pulse[p]) stat_r <= 1'b0;
    end

    assign status[p] = stat_r;

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (evt && clr_pulse[p]) |=> status[p]); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (clr_pulse[p] && !evt) |=> !status[p]); // R7
    AST_DUAL_BOTH: assert property (@(posedge clk) disable iff (rst)
      (edge_q[p] && dual_q[p] && (lvl[p] != lvl_d[p])) |=> status[p]); // R6
  end
endmodule

// File: rtl/gpb_irq_merge.sv
module gpb_irq_merge #(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] status,
  input  logic [NUM_PINS-1:0] en_q,
  output logic [NUM_IRQ-1:0]  irq_out
);
  function automatic logic [NUM_PINS-1:0] group_mask(input int g);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PINS; p++) m[p] = ((p % NUM_IRQ) == g);
    return m;
  endfunction

  logic [NUM_PINS-1:0] pend;
  assign pend = status & en_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    localparam logic [NUM_PINS-1:0] GMASK = group_mask(g);
    always_ff @(posedge clk) begin
      if (rst) irq_out[g] <= 1'b0;
      else     irq_out[g] <= |(pend & GMASK);
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> (irq_out == '0)); // R8
endmodule

// File: rtl/pinbyte_gpio_irq.sv
module pinbyte_gpio_irq #(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 7,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_IRQ-1:0]  irq_out
);
  logic [NUM_PINS-1:0] lvl, lvl_d, status, clr_pulse;
  logic [NUM_PINS-1:0] dir_q, out_q, en_q, pol_q, edge_q, dual_q;

  gpb_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .lvl(lvl), .lvl_d(lvl_d)
  );

  gpb_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .sync_lvl(lvl), .status(status),
    .dir_q(dir_q), .out_q(out_q), .en_q(en_q), .pol_q(pol_q),
    .edge_q(edge_q), .dual_q(dual_q), .clr_pulse(clr_pulse),
    .rdata(bus_rdata)
  );

  gpb_event #(.NUM_PINS(NUM_PINS)) u_evt (
    .clk(clk), .rst(rst), .lvl(lvl), .lvl_d(lvl_d), .edge_q(edge_q),
    .dual_q(dual_q), .pol_q(pol_q), .clr_pulse(clr_pulse), .status(status)
  );

  gpb_irq_merge #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst), .status(status), .en_q(en_q), .irq_out(irq_out)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> ((irq_out == '0) && (pin_oe == '1) && (pin_out == '0))); // R1
endmodule

// File: tb/sim_pinbyte_gpio_irq.sv
module sim_pinbyte_gpio_irq;
  localparam int NP = 16;
  localparam int NI = 7;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr, bus_rd;
  logic [11:0]   bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_oe, pin_out;
  logic [NI-1:0] irq_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  pinbyte_gpio_irq #(.NUM_PINS(NP), .NUM_IRQ(NI), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq_out(irq_out)
  );

  // {edge, dual, pol, start level, end level, expected status}
  localparam logic [5:0] VEC [11] = '{
    6'b001_01_1, 6'b001_00_0, 6'b000_10_1, 6'b000_11_0,
    6'b101_01_1, 6'b101_10_0, 6'b100_10_1, 6'b100_01_0,
    6'b111_10_1, 6'b110_01_1, 6'b110_10_1
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 oe", 8'(pin_oe == '1), 8'd1);
    chk("R1 out", 8'(pin_out), 8'd0);
    chk("R1 irq", 8'(irq_out), 8'd0);
    br(12'h805, rv); chk("R1 dir readback", rv, 8'h00);

    // R2 direction and output level
    bw(12'h901, 8'h01);
    chk("R2 out drive", 8'(pin_out[1]), 8'd1);
    chk("R2 oe output", 8'(pin_oe[1]), 8'd1);
    bw(12'h802, 8'hFF);
    chk("R2 oe input", 8'(pin_oe[2]), 8'd0);
    br(12'h802, rv); chk("R2 R10 dir readback", rv, 8'h01);
    br(12'h901, rv); chk("R2 out readback", rv, 8'h01);

    // R3 synchronised input read
    pin_in[7] = 1'b1;
    idle(3);
    br(12'hA07, rv); chk("R3 input high", rv, 8'h01);
    pin_in[7] = 1'b0;
    br(12'hA07, rv); chk("R3 sync latency", rv, 8'h01);
    idle(3);
    br(12'hA07, rv); chk("R3 input low", rv, 8'h00);

    // R4 R5 R6 R8 vector table on pin 3 (irq line 3)
    for (int i = 0; i < 11; i++) begin
      logic [5:0] v;
      string tag;
      v = VEC[i];
      tag = !v[5] ? "R4" : (v[4] ? "R6" : "R5");
      pin_in[3] = v[2];
      idle(4);
      bw(12'hC03, {7'b0, v[3]});
      bw(12'hD03, {7'b0, v[5]});
      bw(12'hF83, {7'b0, v[4]});
      bw(12'hB03, 8'h01);
      idle(3);
      bw(12'hE03, 8'h01);
      idle(1);
      pin_in[3] = v[1];
      idle(6);
      br(12'hF03, rv); chk(tag, rv, {7'b0, v[0]});
      chk("R8 irq line 3", 8'(irq_out[3]), {7'b0, v[0]});
    end

    // R7 clear behaviour on pin 4
    bw(12'hC04, 8'h01);
    bw(12'hD04, 8'h01);
    idle(2);
    bw(12'hE04, 8'h01);
    pin_in[4] = 1'b1;
    idle(5);
    br(12'hF04, rv); chk("R7 set before clear", rv, 8'h01);
    bw(12'hE04, 8'hFE);
    br(12'hF04, rv); chk("R7 clear with bit0=0 ignored", rv, 8'h01);
    br(12'hE04, rv); chk("R7 clear reads 0", rv, 8'h00);
    bw(12'hE04, 8'h01);
    br(12'hF04, rv); chk("R7 cleared", rv, 8'h00);

    // R8 masking, pin 10 shares line 3
    bw(12'hB03, 8'h00);
    bw(12'hE03, 8'h01);
    bw(12'hC0A, 8'h01);
    bw(12'hD0A, 8'h01);
    idle(2);
    bw(12'hE0A, 8'h01);
    pin_in[10] = 1'b1;
    idle(5);
    br(12'hF0A, rv); chk("R8 status latches while masked", rv, 8'h01);
    chk("R8 masked no irq", 8'(irq_out[3]), 8'd0);
    bw(12'hB0A, 8'h01);
    idle(1);
    chk("R8 unmasked irq", 8'(irq_out[3]), 8'd1);
    chk("R8 other line quiet", 8'(irq_out[0]), 8'd0);
    bw(12'hE0A, 8'h01);
    idle(1);
    chk("R8 irq drops after clear", 8'(irq_out[3]), 8'd0);

    // R9 rising event and clear write in the same cycle, pin 5
    bw(12'hC05, 8'h01);
    bw(12'hD05, 8'h01);
    idle(2);
    bw(12'hE05, 8'h01);
    @(negedge clk);
    pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'hE05; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    br(12'hF05, rv); chk("R9 event wins over clear", rv, 8'h01);
    bw(12'hE05, 8'h01);
    br(12'hF05, rv); chk("R9 later clear takes effect", rv, 8'h00);

    // R10 address range and stored width
    br(12'h7FF, rv); chk("R10 unmapped read", rv, 8'h00);
    bw(12'h81F, 8'h01);
    br(12'h81F, rv); chk("R10 pin beyond range", rv, 8'h00);
    bw(12'h906, 8'hFE);
    br(12'h906, rv); chk("R10 only bit0 stored", rv, 8'h00);
    chk("R10 pin_out unchanged", 8'(pin_out[6]), 8'd0);

    finish_run();
  end
endmodule